// File: doc/BRIEF.md
# Resident Page Use Tracker

This block keeps track of which memory pages hold at least one resident cache line. It does not know about tags, data or memory traffic. It only sees line events from the surrounding cache: a fill that carries the address of the line being brought in, and an optional eviction that carries the address of the line being thrown out. Both events can arrive in the same cycle.

A small associative table holds one entry per tracked page, and each entry counts the resident lines in that page. A fill into a tracked page raises its count. A fill into an untracked page allocates a new entry, and this is counted as a page-map miss. An eviction lowers the count of its page, and the entry is released when the count reaches zero. A combinational query port lets the surrounding logic ask whether a page is tracked and how many lines it holds.

Table occupancy is held in a three-state machine:
- ST_EMPTY: no valid entries.
- ST_PARTIAL: some, but not all, entries are valid.
- ST_FULL: every entry is valid.

The transitions are:
- EMPTY to PARTIAL (or EMPTY to FULL): on the first allocation.
- PARTIAL to FULL: when the last free slot is allocated.
- PARTIAL to EMPTY: when the last entry is released.
- FULL to PARTIAL (or FULL to EMPTY): on a release that is not offset by an allocation.

Top module: `page_use_tracker`

## Requirements
- R1: After reset, no page is tracked: `active_pages`=0, `map_misses`=0, `overflow`=0, `table_full`=0, and every query returns `query_hit`=0 and `query_count`=0.
- R2: The page of an address is the address with its low log2(PAGE_WORDS) bits cleared (PAGE_WORDS=64 by default). Two addresses in the same page share one entry.
- R3: A fill whose page is already tracked raises that page's count by one. It leaves `map_misses` and `active_pages` unchanged.
- R4: A fill whose page is untracked, while a slot is free, allocates an entry with count 1 in the lowest free slot. It raises `active_pages` by one and `map_misses` by one.
- R5: An eviction whose page is tracked lowers that page's count by one. When the count reaches zero, the entry is released and `active_pages` drops by one.
- R6: An eviction whose page is untracked changes nothing: counts, `active_pages` and `map_misses` keep their values.
- R7: When a fill and an eviction occur in the same cycle, the eviction is applied first. A page released by that eviction is therefore re-allocated by the fill, with count 1, and a map miss is counted. A slot freed by that eviction is available to the fill.
- R8: A fill whose page is untracked, while no slot is free (after the same-cycle eviction), is not tracked. `map_misses` still rises by one, `active_pages` is unchanged, and `overflow` is 1 for exactly the next cycle.
- R9: `table_full` is 1 exactly when `active_pages` equals ENTRIES (state ST_FULL).
- R10: The query port is combinational on the stored table. `query_hit` reports whether the page of `query_addr` is tracked, and `query_count` gives its count (0 when untracked).
- R11: All updates from fill and eviction events become visible at the outputs one clock edge after the event is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A line fill occurs this cycle |
| fill_addr | input | ADDR_W | Address of the filled line |
| evict_valid | input | 1 | A line eviction occurs this cycle |
| evict_addr | input | ADDR_W | Address of the evicted line |
| query_addr | input | ADDR_W | Address whose page is looked up |
| query_hit | output | 1 | Page of `query_addr` is tracked |
| query_count | output | CNT_W | Resident line count of that page |
| active_pages | output | clog2(ENTRIES+1) | Number of tracked pages |
| map_misses | output | MISS_W | Fills that found no entry for their page |
| overflow | output | 1 | Previous cycle's fill could not be tracked |
| table_full | output | 1 | Every entry is in use |

## Verification
Some properties are checked on every cycle:
- `active_pages` agrees with the number of valid entries.
- No two valid entries hold the same page.
- Every valid entry has a non-zero count.
- The miss counter moves by at most one per cycle.
- `overflow` only follows a cycle in which the table was full.
- `table_full` agrees with `active_pages`.

Some behaviours only the scenarios can show:
- That a fill actually lands in the right page.
- That a same-cycle eviction is applied before the fill.
- That an eviction into an untracked page leaves the counts alone.
- That a rejected fill is still counted as a miss.

These are compared against a page-indexed reference model.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/ptrk_match.sv
module ptrk_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [$clog2(ENTRIES)-1:0]     idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    // Scan from the top down so that the lowest matching slot wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid[i] && (tags[i] == key)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ptrk_alloc.sv
module ptrk_alloc #(
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0]         valid,
    output logic                       any_free,
    output logic [$clog2(ENTRIES)-1:0] free_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    // Lowest-numbered free slot.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/page_use_tracker.sv
module page_use_tracker
    import ptrk_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_WORDS = 64,
    parameter int ENTRIES    = 4,
    parameter int CNT_W      = 8,
    parameter int MISS_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fill_valid,
    input  logic [ADDR_W-1:0]            fill_addr,
    input  logic                         evict_valid,
    input  logic [ADDR_W-1:0]            evict_addr,
    input  logic [ADDR_W-1:0]            query_addr,
    output logic                         query_hit,
    output logic [CNT_W-1:0]             query_count,
    output logic [$clog2(ENTRIES+1)-1:0] active_pages,
    output logic [MISS_W-1:0]            map_misses,
    output logic                         overflow,
    output logic                         table_full
);
    localparam int OFF_W = $clog2(PAGE_WORDS);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int ACT_W = $clog2(ENTRIES + 1);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));
    localparam logic [ACT_W-1:0]  FULL_CNT  = ACT_W'(ENTRIES);

    // Stored table
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q;
    logic [ACT_W-1:0]               active_q;
    logic [MISS_W-1:0]              miss_q;
    logic                           ovf_q;
    occ_state_e                     state_q;

    // Next-state signals
    logic [ENTRIES-1:0]             valid_mid, valid_d;
    logic [ENTRIES-1:0][CNT_W-1:0]  cnt_mid, cnt_d;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_d;
    logic [ACT_W-1:0]               active_d;
    occ_state_e                     state_d;
    logic                           release_ev, alloc_ev, miss_ev, reject_ev;

    logic [ADDR_W-1:0] ev_page, fl_page, q_page;
    logic              ev_hit, fl_hit, q_hit, free_any;
    logic [IDX_W-1:0]  ev_idx, fl_idx, q_idx, free_idx;

    assign ev_page = evict_addr & PAGE_MASK;
    assign fl_page = fill_addr  & PAGE_MASK;
    assign q_page  = query_addr & PAGE_MASK;

    // Eviction lookup on the stored table
    ptrk_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ev_match (
        .valid(valid_q), .tags(tag_q), .key(ev_page), .hit(ev_hit), .idx(ev_idx)
    );

    // Eviction is applied first
    always_comb begin
        valid_mid  = valid_q;
        cnt_mid    = cnt_q;
        release_ev = 1'b0;
        if (evict_valid && ev_hit) begin
            cnt_mid[ev_idx] = cnt_q[ev_idx] - CNT_W'(1);
            if (cnt_q[ev_idx] <= CNT_W'(1)) begin
                valid_mid[ev_idx] = 1'b0;
                cnt_mid[ev_idx]   = '0;
                release_ev        = 1'b1;
            end
        end
    end

    // Fill lookup and allocation on the post-eviction table
    ptrk_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fl_match (
        .valid(valid_mid), .tags(tag_q), .key(fl_page), .hit(fl_hit), .idx(fl_idx)
    );

    ptrk_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .valid(valid_mid), .any_free(free_any), .free_idx(free_idx)
    );

    always_comb begin
        valid_d   = valid_mid;
        cnt_d     = cnt_mid;
        tag_d     = tag_q;
        alloc_ev  = 1'b0;
        miss_ev   = 1'b0;
        reject_ev = 1'b0;
        if (fill_valid) begin
            if (fl_hit) begin
                cnt_d[fl_idx] = cnt_mid[fl_idx] + CNT_W'(1);
            end else begin
                miss_ev = 1'b1;
                if (free_any) begin
                    valid_d[free_idx] = 1'b1;
                    tag_d[free_idx]   = fl_page;
                    cnt_d[free_idx]   = CNT_W'(1);
                    alloc_ev          = 1'b1;
                end else begin
                    reject_ev = 1'b1;
                end
            end
        end
    end

    always_comb begin
        active_d = active_q;
        if (alloc_ev && !release_ev)      active_d = active_q + ACT_W'(1);
        else if (release_ev && !alloc_ev) active_d = active_q - ACT_W'(1);
    end

    // Occupancy state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (active_d != '0)
                    state_d = (active_d == FULL_CNT) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (active_d == '0)           state_d = ST_EMPTY;
                else if (active_d == FULL_CNT) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (active_d != FULL_CNT)
                    state_d = (active_d == '0) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register and table
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            valid_q  <= '0;
            tag_q    <= '0;
            cnt_q    <= '0;
            active_q <= '0;
            miss_q   <= '0;
            ovf_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            valid_q  <= valid_d;
            tag_q    <= tag_d;
            cnt_q    <= cnt_d;
            active_q <= active_d;
            miss_q   <= miss_q + MISS_W'(miss_ev);
            ovf_q    <= reject_ev;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_EMPTY:   table_full = 1'b0;
            ST_PARTIAL: table_full = 1'b0;
            ST_FULL:    table_full = 1'b1;
            default:    table_full = 1'b0;
        endcase
    end

    ptrk_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_q_match (
        .valid(valid_q), .tags(tag_q), .key(q_page), .hit(q_hit), .idx(q_idx)
    );

    assign query_hit    = q_hit;
    assign query_count  = q_hit ? cnt_q[q_idx] : '0;
    assign active_pages = active_q;
    assign map_misses   = miss_q;
    assign overflow     = ovf_q;
endmodule

// File: rtl/page_use_tracker_chk.sv
module page_use_tracker_chk #(
    parameter int ADDR_W  = 16,
    parameter int ENTRIES = 4,
    parameter int CNT_W   = 8,
    parameter int MISS_W  = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [ENTRIES-1:0]               valid_q,
    input logic [ENTRIES-1:0][ADDR_W-1:0]   tag_q,
    input logic [ENTRIES-1:0][CNT_W-1:0]    cnt_q,
    input logic [$clog2(ENTRIES+1)-1:0]     active_pages,
    input logic [MISS_W-1:0]                map_misses,
    input logic                             overflow,
    input logic                             table_full
);
    localparam int ACT_W = $clog2(ENTRIES + 1);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (active_pages == '0 && map_misses == '0 && !overflow && !table_full));

    p_active_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active_pages == ACT_W'($countones(valid_q)));

    p_miss_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (map_misses == $past(map_misses) || map_misses == $past(map_misses) + MISS_W'(1)));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (overflow |-> $past(table_full)));

    p_full_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        table_full == (active_pages == ACT_W'(ENTRIES)));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        p_live_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[i] |-> (cnt_q[i] != '0));
        for (genvar j = i + 1; j < ENTRIES; j++) begin : g_pair
            p_unique_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !(valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]));
        end
    end
endmodule

bind page_use_tracker page_use_tracker_chk #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W), .MISS_W(MISS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .tag_q(tag_q), .cnt_q(cnt_q),
    .active_pages(active_pages), .map_misses(map_misses), .overflow(overflow),
    .table_full(table_full)
);

// File: tb/page_use_tracker_bench.sv
`timescale 1ns/100ps
module page_use_tracker_bench;
    localparam int ADDR_W = 16, PAGE_WORDS = 64, ENTRIES = 4, CNT_W = 8, MISS_W = 16;
    localparam int NPAGES = (1 << ADDR_W) / PAGE_WORDS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_valid = 1'b0, evict_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0, evict_addr = '0, query_addr = '0;
    logic query_hit, overflow, table_full;
    logic [CNT_W-1:0] query_count;
    logic [$clog2(ENTRIES+1)-1:0] active_pages;
    logic [MISS_W-1:0] map_misses;

    always #4 clk = ~clk;

    page_use_tracker #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS), .ENTRIES(ENTRIES),
                       .CNT_W(CNT_W), .MISS_W(MISS_W)) u_page_use_tracker (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .query_addr(query_addr),
        .query_hit(query_hit), .query_count(query_count), .active_pages(active_pages),
        .map_misses(map_misses), .overflow(overflow), .table_full(table_full)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int m_cnt [NPAGES];
    int m_miss = 0;
    bit m_ovf = 1'b0;

    function automatic int m_active();
        int n = 0;
        for (int p = 0; p < NPAGES; p++) if (m_cnt[p] > 0) n++;
        return n;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference update: eviction first, then fill
    task automatic model(input bit fv, input int fa, input bit ev, input int ea);
        int ep = ea / PAGE_WORDS;
        int fp = fa / PAGE_WORDS;
        m_ovf = 1'b0;
        if (ev && m_cnt[ep] > 0) m_cnt[ep]--;
        if (fv) begin
            if (m_cnt[fp] > 0) m_cnt[fp]++;
            else begin
                m_miss++;
                if (m_active() < ENTRIES) m_cnt[fp] = 1;
                else m_ovf = 1'b1;
            end
        end
    endtask

    task automatic probe(input int addr, input string req);
        query_addr = ADDR_W'(addr);
        #0.5;
        check(int'(query_hit), (m_cnt[addr / PAGE_WORDS] > 0) ? 1 : 0, req);
        check(int'(query_count), m_cnt[addr / PAGE_WORDS], req);
    endtask

    task automatic check_outputs(input string req);
        check(int'(active_pages), m_active(), req);
        check(int'(map_misses), m_miss, req);
        check(int'(overflow), int'(m_ovf), req);
        check(int'(table_full), (m_active() == ENTRIES) ? 1 : 0, {req, "/R9"});
    endtask

    // Present one cycle of events at a falling edge, check after the next rising edge.
    task automatic step(input bit fv, input int fa, input bit ev, input int ea, input string req);
        fill_valid  = fv;
        fill_addr   = ADDR_W'(fa);
        evict_valid = ev;
        evict_addr  = ADDR_W'(ea);
        model(fv, fa, ev, ea);
        @(posedge clk);
        @(negedge clk);
        fill_valid  = 1'b0;
        evict_valid = 1'b0;
        check_outputs({req, "/R11"});
        probe(fa, {req, "/R10"});
        probe(ea, {req, "/R10"});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int p = 0; p < NPAGES; p++) m_cnt[p] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_outputs("R1");
        probe(16'h0000, "R1");
        rst_n = 1'b1;

        step(1, 16'h0005, 0, 0, "R4");
        step(1, 16'h003F, 0, 0, "R2 R3");
        step(1, 16'h0040, 0, 0, "R4");
        step(0, 0, 1, 16'h0010, "R5");
        step(0, 16'h0040, 1, 16'h0300, "R6");
        step(1, 16'h0002, 1, 16'h0001, "R7");
        step(1, 16'h0080, 0, 0, "R4");
        step(1, 16'h00C0, 0, 0, "R9");
        step(1, 16'h0100, 0, 0, "R8");
        step(0, 16'h0100, 0, 0, "R8");
        step(1, 16'h0101, 1, 16'h0041, "R7 R8");
        step(1, 16'h0140, 1, 16'h0000, "R8");

        for (int n = 0; n < 1500; n++) begin
            int fpg = int'($urandom_range(0, 7));
            int epg = int'($urandom_range(0, 8));
            bit fv = ($urandom_range(0, 99) < 55);
            bit ev = ($urandom_range(0, 99) < 60);
            step(fv, fpg * PAGE_WORDS + int'($urandom_range(0, PAGE_WORDS - 1)),
                 ev, epg * PAGE_WORDS + int'($urandom_range(0, PAGE_WORDS - 1)),
                 "R3 R4 R5 R6 R7 R8");
        end

        // A reset in mid-run clears everything again.
        rst_n = 1'b0;
        for (int p = 0; p < NPAGES; p++) m_cnt[p] = 0;
        m_miss = 0;
        m_ovf  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_outputs("R1");
        probe(16'h0040, "R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule